// File: doc/BRIEF.md
# Firmware Image Loader with Validation

This block accepts a firmware image as a stream of 32-bit words whose total count is given when the load is requested. Every word is captured in an internal image buffer. The header and the block table are then checked in full against the buffered image, and only after that are the code blocks replayed as write commands to one of two target memories: an instruction store or a data store. At the end of each load the block gives a single completion pulse and an error code that explains the result.

Images may arrive in either byte order. The first word tells the loader which order was used. If the image is byte-reversed, every word after the first is reversed back as it is stored. The header carries an identifier, which is matched against the engine number the caller supplies and, on older devices, against a device-class restriction. The payload opens with a table of (type, offset) pairs that ends in an end entry. Each offset points at a code block, and each code block holds a target address, a word count and the data words.

Top module: `fw_image_loader`

## Requirements
- R1: A first word of 0xFEEDF00D marks a native image. A first word of 0x0DF0EDFE marks a reversed image, and every later word then has its four bytes reversed before use. Any other first word ends the load with error code 1.
- R2: The header is word 0 (magic), word 1 (identifier) and word 2 (payload size in words). The load fails with code 2 when total_words is below 3, when total_words differs from size+3, or when total_words exceeds the buffer depth. When several header checks fail, the first of these decides the code: total below 3, then magic (R1), then the size match, then the identifier (R3).
- R3: Identifier bits 27:24 must equal engine_sel. When legacy_dev is high, identifier bits 31:28 must be zero. Either violation gives code 3.
- R4: The table entry k of the payload occupies payload words 2k (type) and 2k+1 (offset). Payload word p is image word p+3. A type of 0 selects the instruction store, 1 selects the data store and 0xF ends the table. If no end entry starts at a payload word below size, the load fails with code 4.
- R5: With nb entries before the end entry, every offset must be at least 2·nb+1 and no more than size−2. Otherwise the load fails with code 5.
- R6: An entry type other than 0, 1 or 0xF gives code 6. Entries are checked in table order. Within an entry the offset check comes first, then the type check, then the bounds checks (R7).
- R7: A code block holds its target address at payload[off], its count at payload[off+1] and its data after that. The load fails with code 7 if address+count exceeds IMEM_DEPTH for type 0 or DMEM_DEPTH for type 1, or if off+2+count exceeds size. A block that ends exactly at the memory depth is accepted.
- R8: A start while target_running is high finishes with busy_err high. It consumes no stream words and issues no writes.
- R9: No write is issued until every table entry has passed. A load that fails issues no writes at all.
- R10: Writes use a valid/ready handshake. They come out in table order and at ascending addresses within each block. wr_sel is 0 for the instruction store and 1 for the data store, and wr_data is the payload word at off+2+j for address+j. While wr_valid is high and wr_ready is low, wr_sel, wr_addr and wr_data are held.
- R11: done is high for exactly one cycle per load. err_code is 0 on success and keeps its value after done until the next start.
- R12: in_ready is high only while the image is being received. Exactly total_words words are accepted per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request, sampled while idle |
| total_words | input | 32 | Image length in words, captured at start |
| engine_sel | input | 4 | Engine number the identifier must match |
| legacy_dev | input | 1 | Reject images with a nonzero device class |
| target_running | input | 1 | Refuse the load with a busy result |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted |
| in_data | input | 32 | Stream word |
| wr_valid | output | 1 | Memory write valid |
| wr_ready | input | 1 | Memory write accepted |
| wr_sel | output | 1 | 0 instruction store, 1 data store |
| wr_addr | output | ADDR_W | Word address in the selected store |
| wr_data | output | 32 | Word to write |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code: 0 ok, 1 magic, 2 size, 3 id, 4 no end, 5 offset, 6 type, 7 overflow |
| busy_err | output | 1 | Load refused because the target was running |

## Verification
The bench targets the bound edges. These are a block that ends exactly at the instruction store depth, offsets just below the table end and just above size−2, and a data block that runs one word past the payload. An off-by-one comparison would flip pass and fail at these points. A reversed image must yield the same write list as the native image, so a loader that forgot to swap would show wrong addresses or wrong data. Every failing image is followed by a check that no write appeared, which catches a design that starts writing before the whole table is validated. A random wr_ready pattern exposes write fields that drift during a stall.

// File: rtl/fw_ldr_pkg.sv
package fw_ldr_pkg;

    localparam logic [31:0] IMG_MAGIC  = 32'hFEEDF00D;
    localparam logic [31:0] TYPE_INSTR = 32'h0;
    localparam logic [31:0] TYPE_DATA  = 32'h1;
    localparam logic [31:0] TYPE_END   = 32'hF;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_MAGIC    = 3'd1,
        ERR_SIZE     = 3'd2,
        ERR_ID       = 3'd3,
        ERR_NOEND    = 3'd4,
        ERR_OFFSET   = 3'd5,
        ERR_TYPE     = 3'd6,
        ERR_OVERFLOW = 3'd7
    } ldr_err_e;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_RECV = 3'd1,
        PH_HDR  = 3'd2,
        PH_FIND = 3'd3,
        PH_ENT  = 3'd4,
        PH_CB   = 3'd5,
        PH_WR   = 3'd6,
        PH_FIN  = 3'd7
    } ldr_phase_e;

    function automatic logic [31:0] bswap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/fw_img_buf.sv
module fw_img_buf #(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        wr_en,
    input  logic [31:0] wr_idx,
    input  logic [31:0] wr_word,
    input  logic        swap_en,
    input  logic [31:0] rd_idx_a,
    output logic [31:0] rd_word_a,
    input  logic [31:0] rd_idx_b,
    output logic [31:0] rd_word_b
);
    import fw_ldr_pkg::*;

    localparam logic [31:0] LIM = 32'(DEPTH);

    logic [31:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_idx < LIM)) begin
            mem_q[wr_idx[IDX_W-1:0]] <= swap_en ? bswap32(wr_word) : wr_word;
        end
    end

    // Out-of-range reads return zero; callers only consume in-range words.
    assign rd_word_a = (rd_idx_a < LIM) ? mem_q[rd_idx_a[IDX_W-1:0]] : '0;
    assign rd_word_b = (rd_idx_b < LIM) ? mem_q[rd_idx_b[IDX_W-1:0]] : '0;

endmodule

// File: rtl/fw_hdr_check.sv
module fw_hdr_check #(
    parameter int IMG_DEPTH = 64
) (
    input  logic        magic_ok,
    input  logic [31:0] total_words,
    input  logic [7:0]  id_hi,
    input  logic [31:0] size_word,
    input  logic [3:0]  engine_sel,
    input  logic        legacy_dev,
    output logic [2:0]  hdr_err
);
    import fw_ldr_pkg::*;

    localparam logic [31:0] CAP = 32'(IMG_DEPTH);

    always_comb begin
        hdr_err = ERR_NONE;
        if (total_words < 32'd3) begin
            hdr_err = ERR_SIZE;
        end else if (!magic_ok) begin
            hdr_err = ERR_MAGIC;
        end else if (({1'b0, total_words} != ({1'b0, size_word} + 33'd3)) ||
                     (total_words > CAP)) begin
            hdr_err = ERR_SIZE;
        end else if (id_hi[3:0] != engine_sel) begin
            hdr_err = ERR_ID;
        end else if (legacy_dev && (id_hi[7:4] != 4'd0)) begin
            hdr_err = ERR_ID;
        end
    end

endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
    parameter int IMG_DEPTH  = 64,
    parameter int IMEM_DEPTH = 16,
    parameter int DMEM_DEPTH = 8,
    parameter int ADDR_W     = $clog2((IMEM_DEPTH > DMEM_DEPTH) ? IMEM_DEPTH : DMEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       total_words,
    input  logic [3:0]        engine_sel,
    input  logic              legacy_dev,
    input  logic              target_running,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              done,
    output logic [2:0]        err_code,
    output logic              busy_err
);
    import fw_ldr_pkg::*;

    localparam logic [32:0] IMEM_LIM = 33'(IMEM_DEPTH);
    localparam logic [32:0] DMEM_LIM = 33'(DMEM_DEPTH);

    typedef struct packed {
        ldr_phase_e  phase;
        logic [31:0] total;
        logic [31:0] wcnt;
        logic        swap;
        logic        magic_ok;
        logic [31:0] size;
        logic [31:0] ent;
        logic [31:0] nblk;
        logic        pass;
        logic [31:0] off;
        logic        sel;
        logic [31:0] naddr;
        logic [31:0] cnt;
        logic [31:0] j;
        logic [2:0]  err;
        logic        busy;
    } ldr_state_t;

    ldr_state_t  st_q, st_d;
    logic [31:0] ridx_a, ridx_b, rword_a, rword_b;
    logic        buf_we;
    logic [2:0]  hdr_err;

    fw_img_buf #(.DEPTH(IMG_DEPTH)) u_buf (
        .clk       (clk),
        .wr_en     (buf_we),
        .wr_idx    (st_q.wcnt),
        .wr_word   (in_data),
        .swap_en   (st_q.swap && (st_q.wcnt != 32'd0)),
        .rd_idx_a  (ridx_a),
        .rd_word_a (rword_a),
        .rd_idx_b  (ridx_b),
        .rd_word_b (rword_b)
    );

    fw_hdr_check #(.IMG_DEPTH(IMG_DEPTH)) u_hdr (
        .magic_ok    (st_q.magic_ok),
        .total_words (st_q.total),
        .id_hi       (rword_a[31:24]),
        .size_word   (rword_b),
        .engine_sel  (engine_sel),
        .legacy_dev  (legacy_dev),
        .hdr_err     (hdr_err)
    );

    always_comb begin
        st_d   = st_q;
        ridx_a = '0;
        ridx_b = '0;
        buf_we = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.err      = ERR_NONE;
                    st_d.busy     = 1'b0;
                    st_d.total    = total_words;
                    st_d.wcnt     = '0;
                    st_d.swap     = 1'b0;
                    st_d.magic_ok = 1'b0;
                    st_d.ent      = '0;
                    st_d.pass     = 1'b0;
                    if (target_running) begin
                        st_d.busy  = 1'b1;
                        st_d.phase = PH_FIN;
                    end else begin
                        st_d.phase = PH_RECV;
                    end
                end
            end
            PH_RECV: begin
                if (st_q.wcnt == st_q.total) begin
                    st_d.phase = PH_HDR;
                end else if (in_valid) begin
                    buf_we    = 1'b1;
                    st_d.wcnt = st_q.wcnt + 32'd1;
                    if (st_q.wcnt == 32'd0) begin
                        st_d.swap     = (in_data == bswap32(IMG_MAGIC));
                        st_d.magic_ok = (in_data == IMG_MAGIC) ||
                                        (in_data == bswap32(IMG_MAGIC));
                    end
                end
            end
            PH_HDR: begin
                ridx_a    = 32'd1;
                ridx_b    = 32'd2;
                st_d.size = rword_b;
                if (hdr_err != ERR_NONE) begin
                    st_d.err   = hdr_err;
                    st_d.phase = PH_FIN;
                end else begin
                    st_d.phase = PH_FIND;
                end
            end
            PH_FIND: begin
                ridx_a = 32'd3 + {st_q.ent[30:0], 1'b0};
                if ({st_q.ent, 1'b0} >= {1'b0, st_q.size}) begin
                    st_d.err   = ERR_NOEND;
                    st_d.phase = PH_FIN;
                end else if (rword_a == TYPE_END) begin
                    st_d.nblk  = st_q.ent;
                    st_d.ent   = '0;
                    st_d.phase = PH_ENT;
                end else begin
                    st_d.ent = st_q.ent + 32'd1;
                end
            end
            PH_ENT: begin
                ridx_a = 32'd3 + {st_q.ent[30:0], 1'b0};
                ridx_b = 32'd4 + {st_q.ent[30:0], 1'b0};
                if (st_q.ent == st_q.nblk) begin
                    if (!st_q.pass) begin
                        st_d.pass = 1'b1;
                        st_d.ent  = '0;
                    end else begin
                        st_d.phase = PH_FIN;
                    end
                end else if (!st_q.pass &&
                             (({1'b0, rword_b} < {st_q.nblk, 1'b1}) ||
                              (({1'b0, rword_b} + 33'd2) > {1'b0, st_q.size}))) begin
                    st_d.err   = ERR_OFFSET;
                    st_d.phase = PH_FIN;
                end else if ((rword_a != TYPE_INSTR) && (rword_a != TYPE_DATA)) begin
                    st_d.err   = ERR_TYPE;
                    st_d.phase = PH_FIN;
                end else begin
                    st_d.off   = rword_b;
                    st_d.sel   = rword_a[0];
                    st_d.phase = PH_CB;
                end
            end
            PH_CB: begin
                ridx_a = 32'd3 + st_q.off;
                ridx_b = 32'd4 + st_q.off;
                if (!st_q.pass) begin
                    if ((({1'b0, rword_a} + {1'b0, rword_b}) >
                         (st_q.sel ? DMEM_LIM : IMEM_LIM)) ||
                        (({1'b0, st_q.off} + 33'd2 + {1'b0, rword_b}) >
                         {1'b0, st_q.size})) begin
                        st_d.err   = ERR_OVERFLOW;
                        st_d.phase = PH_FIN;
                    end else begin
                        st_d.ent   = st_q.ent + 32'd1;
                        st_d.phase = PH_ENT;
                    end
                end else begin
                    st_d.naddr = rword_a;
                    st_d.cnt   = rword_b;
                    st_d.j     = '0;
                    if (rword_b == 32'd0) begin
                        st_d.ent   = st_q.ent + 32'd1;
                        st_d.phase = PH_ENT;
                    end else begin
                        st_d.phase = PH_WR;
                    end
                end
            end
            PH_WR: begin
                ridx_a = 32'd5 + st_q.off + st_q.j;
                if (wr_ready) begin
                    if ((st_q.j + 32'd1) == st_q.cnt) begin
                        st_d.ent   = st_q.ent + 32'd1;
                        st_d.phase = PH_ENT;
                    end else begin
                        st_d.j = st_q.j + 32'd1;
                    end
                end
            end
            PH_FIN: begin
                st_d.phase = PH_IDLE;
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready = (st_q.phase == PH_RECV) && (st_q.wcnt != st_q.total);
    assign wr_valid = (st_q.phase == PH_WR);
    assign wr_sel   = st_q.sel;
    assign wr_addr  = ADDR_W'(st_q.naddr + st_q.j);
    assign wr_data  = rword_a;
    assign done     = (st_q.phase == PH_FIN);
    assign err_code = st_q.err;
    assign busy_err = st_q.busy;

endmodule

// File: rtl/fw_image_loader_chk.sv
module fw_image_loader_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_sel,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              done,
    input logic [2:0]        err_code,
    input logic              busy_err
);
    logic wrote_q, took_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wrote_q <= 1'b0;
            took_q  <= 1'b0;
        end else if (done) begin
            wrote_q <= 1'b0;
            took_q  <= 1'b0;
        end else begin
            if (wr_valid && wr_ready) wrote_q <= 1'b1;
            if (in_valid && in_ready) took_q  <= 1'b1;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) &&
                                     $stable(wr_data) && $stable(wr_sel)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && wr_valid));

    assert_no_write_on_fail_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (err_code != 3'd0)) |-> !wrote_q);

    assert_busy_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_err) |-> (!took_q && !wrote_q));

endmodule

bind fw_image_loader fw_image_loader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/fw_image_loader_tb.sv
module fw_image_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IMG_DEPTH  = 64;
    localparam int IMEM_DEPTH = 16;
    localparam int DMEM_DEPTH = 8;
    localparam int ADDR_W     = 4;
    localparam logic [31:0] MAGIC = 32'hFEEDF00D;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       total_words = '0;
    logic [3:0]        engine_sel = 4'd2;
    logic              legacy_dev = 1'b0;
    logic              target_running = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [31:0]       in_data = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic              wr_sel;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              done;
    logic [2:0]        err_code;
    logic              busy_err;

    fw_image_loader #(
        .IMG_DEPTH(IMG_DEPTH), .IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH)
    ) u_dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } wr_t;

    logic [31:0] img [IMG_DEPTH];
    wr_t exp_q[$];
    int  n_chk = 0, n_fail = 0;
    int  got_writes, accepted;
    bit  swap_tx = 1'b0, rand_ready = 1'b0, done_seen;
    logic [2:0] done_err;
    logic       done_busy;

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Reference model: expected result code and write list from the requirements.
    function automatic int model(input int n);
        longint sz, off, ty, ad, ct;
        int nb;
        wr_t w;
        exp_q.delete();
        if (n < 3) return 2;
        if (img[0] != MAGIC) return 1;
        sz = img[2];
        if (n != sz + 3 || n > IMG_DEPTH) return 2;
        if (img[1][27:24] != engine_sel) return 3;
        if (legacy_dev && img[1][31:28] != 4'd0) return 3;
        nb = 0;
        forever begin
            if (2 * nb >= sz) return 4;
            if (img[3 + 2 * nb] == 32'hF) break;
            nb++;
        end
        for (int k = 0; k < nb; k++) begin
            ty  = img[3 + 2 * k];
            off = img[4 + 2 * k];
            if (off < 2 * nb + 1 || off > sz - 2) return 5;
            if (ty != 0 && ty != 1) return 6;
            ad = img[3 + off];
            ct = img[4 + off];
            if (ad + ct > ((ty == 1) ? DMEM_DEPTH : IMEM_DEPTH)) return 7;
            if (off + 2 + ct > sz) return 7;
        end
        for (int k = 0; k < nb; k++) begin
            off = img[4 + 2 * k];
            ad  = img[3 + off];
            ct  = img[4 + off];
            for (int j = 0; j < ct; j++) begin
                w.sel  = img[3 + 2 * k][0];
                w.addr = ADDR_W'(ad + j);
                w.data = img[5 + off + j];
                exp_q.push_back(w);
            end
        end
        return 0;
    endfunction

    // Write port: drive ready, then compare any handshake against the model.
    always @(negedge clk) begin
        wr_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
        if (rst_n) begin
            if (wr_valid && wr_ready) begin
                got_writes++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected write", {wr_sel, wr_addr, wr_data}, 0);
                end else begin
                    chk({wr_sel, wr_addr, wr_data} == exp_q[0],
                        "R10 write sel/addr/data", {wr_sel, wr_addr, wr_data}, exp_q[0]);
                    void'(exp_q.pop_front());
                end
            end
            if (done) begin
                done_seen = 1'b1;
                done_err  = err_code;
                done_busy = busy_err;
            end
        end
    end

    task automatic build_good();
        for (int i = 0; i < IMG_DEPTH; i++) img[i] = 32'h0;
        img[0] = MAGIC;
        img[1] = {4'h0, 4'h2, 8'h31, 8'h01, 8'h07};
        img[2] = 32'd15;
        img[3] = 32'h0;  img[4] = 32'd6;      // instruction block at payload 6
        img[5] = 32'h1;  img[6] = 32'd11;     // data block at payload 11
        img[7] = 32'hF;  img[8] = 32'h0;      // end entry
        img[9]  = 32'd13; img[10] = 32'd3;    // ends exactly at IMEM_DEPTH
        img[11] = 32'hA5A50001; img[12] = 32'hA5A50002; img[13] = 32'hA5A50003;
        img[14] = 32'd2;  img[15] = 32'd2;
        img[16] = 32'hD00D0001; img[17] = 32'hD00D0002;
    endtask

    task automatic run_load(input int n, input string tag);
        int  exp_err, k, cyc;
        bit  r;
        exp_err    = model(n);
        got_writes = 0;
        accepted   = 0;
        done_seen  = 1'b0;
        @(negedge clk);
        total_words = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        cyc = 0;
        while (!done_seen && cyc < 3000) begin
            if (k < n) begin
                in_valid = 1'b1;
                in_data  = swap_tx ? rev(img[k]) : img[k];
            end else begin
                in_valid = 1'b0;
            end
            r = in_valid && in_ready;
            @(negedge clk);
            cyc++;
            if (r) begin
                k++;
                accepted++;
            end
        end
        in_valid = 1'b0;
        chk(done_seen, {tag, " R11 done seen"}, done_seen, 1);
        chk(done_err == exp_err, {tag, " result code"}, done_err, exp_err);
        chk(accepted == n, {tag, " R12 words accepted"}, accepted, n);
        chk(exp_q.size() == 0, {tag, " R10 writes outstanding"}, exp_q.size(), 0);
        if (exp_err != 0) chk(got_writes == 0, {tag, " R9 no writes on failure"}, got_writes, 0);
        @(negedge clk);
        @(negedge clk);
        chk(err_code == exp_err, {tag, " R11 code held after done"}, err_code, exp_err);
        chk(!done && !in_ready, {tag, " R11 R12 idle after done"}, {done, in_ready}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !wr_valid && !in_ready && err_code == 3'd0,
            "R11 R12 reset state", {done, wr_valid, in_ready, err_code}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        build_good();
        run_load(18, "R10 native image");                 // includes R7 exact fit
        chk(got_writes == 5, "R10 write count", got_writes, 5);

        swap_tx = 1'b1; rand_ready = 1'b1;
        run_load(18, "R1 reversed image, stalled writes");
        swap_tx = 1'b0;

        build_good(); img[0] = 32'h12345678;
        run_load(18, "R1 bad magic");

        build_good();
        run_load(17, "R2 length mismatch");
        run_load(2,  "R2 short image");

        build_good(); engine_sel = 4'd3;
        run_load(18, "R3 engine mismatch");
        engine_sel = 4'd2; legacy_dev = 1'b1;
        run_load(18, "R3 legacy with class 0");
        img[1][31:28] = 4'h1;
        run_load(18, "R3 legacy with nonzero class");
        legacy_dev = 1'b0;

        build_good(); img[7] = 32'h0;
        run_load(18, "R4 missing end entry");

        build_good(); img[4] = 32'd4;
        run_load(18, "R5 offset inside table");
        build_good(); img[6] = 32'd14;
        run_load(18, "R5 offset past size-2");

        build_good(); img[5] = 32'h2;
        run_load(18, "R6 bad entry type");

        build_good(); img[9] = 32'd14;
        run_load(18, "R7 instruction store overflow");
        build_good(); img[14] = 32'd7;
        run_load(18, "R7 data store overflow");
        build_good(); img[15] = 32'd3;
        run_load(18, "R7 block past payload");

        build_good(); target_running = 1'b1;
        done_seen = 1'b0; accepted = 0; got_writes = 0;
        @(negedge clk); total_words = 18; start = 1'b1; in_valid = 1'b1; in_data = MAGIC;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < 20 && !done_seen; c++) begin
            if (in_ready) accepted++;
            @(negedge clk);
        end
        in_valid = 1'b0; target_running = 1'b0;
        chk(done_seen && done_busy, "R8 busy refusal", {done_seen, done_busy}, 2'b11);
        chk(accepted == 0 && got_writes == 0, "R8 nothing consumed or written",
            accepted + got_writes, 0);

        build_good(); rand_ready = 1'b1;
        run_load(18, "R10 R11 good after busy");
        summary();
    end

endmodule